// File: doc/BRIEF.md
# SPI Slave Interrupt Flag Generator

This block turns the status lines of an SPI slave controller into a vector of pending interrupt flags and a single interrupt request. Nine events are tracked. Three come from the FIFO status lines: the transmit side has gone idle, the transmit FIFO has room again, and the receive FIFO holds data. Four come from the buffer-active bits of the two transmit and two receive DMA buffers, and two come from the receive-overrun and transmit-underrun pulses. The status logic itself lives elsewhere. This block only watches those lines and records what happened.

A common mode input selects how the three FIFO events are sensed. In edge mode a flag is raised once, when its status line goes from 0 to 1. In level mode the flag is raised again on every cycle that the line stays high. A DMA buffer counts as finished when its active bit falls from 1 to 0.

Every flag stays set until software writes a one to the matching bit of the clear mask. If a clear and a new event reach the same flag in the same cycle, the event wins. The interrupt line is high whenever the top-level enable is set and at least one pending flag has its own enable bit set.

Top module: `spi_irq_flags`

## Requirements
- R1: While reset is held, and on the first cycle after it, `flags_o` and `irq_o` are zero. A status line that is already high, or a DMA active bit that is already set, while reset is held does not produce an event when reset is released.
- R2: With `level_mode_i` = 0, a 0-to-1 transition of `tx_idle_i`, `tx_free_i` or `rx_valid_i` sets flag bit 0, 1 or 2 on the next clock. If such a flag is cleared while its status line stays high, it does not come back.
- R3: With `level_mode_i` = 1, flag bits 0 to 2 are set on the clock after any cycle in which the matching status line is high. A clear for such a bit does not take effect while its line is high.
- R4: A 1-to-0 transition of `tx_dma_act_i[0]` or `tx_dma_act_i[1]` sets flag bit 3 or 4. A 1-to-0 transition of `rx_dma_act_i[0]` or `rx_dma_act_i[1]` sets flag bit 5 or 6. A 0-to-1 transition of any of these bits sets nothing.
- R5: A cycle with `rx_overrun_i` high sets flag bit 7. A cycle with `tx_underrun_i` high sets flag bit 8.
- R6: A set flag stays set until a cycle in which its bit in `clr_i` is 1. A clear-mask bit of 0 leaves its flag unchanged.
- R7: When a new event and a clear reach the same flag in the same cycle, the flag is set afterwards.
- R8: `irq_o` equals `irq_top_en_i` AND the OR over all bits of (`flags_o` AND `irq_en_i`). It changes in the same cycle as the enable inputs.
- R9: Flags are recorded whatever the enable bits are. A flag that is masked stays pending and raises `irq_o` as soon as its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_idle_i | input | 1 | Status: transmit FIFO empty and the last byte shifted out |
| tx_free_i | input | 1 | Status: transmit FIFO not full |
| rx_valid_i | input | 1 | Status: receive FIFO not empty |
| tx_dma_act_i | input | 2 | Transmit DMA buffer active bits, index 0 = buffer A |
| rx_dma_act_i | input | 2 | Receive DMA buffer active bits, index 0 = buffer A |
| rx_overrun_i | input | 1 | Pulse: a byte was lost because the receive FIFO was full |
| tx_underrun_i | input | 1 | Pulse: a byte was sent while the transmit FIFO was empty |
| irq_en_i | input | 9 | Enable bit for each flag |
| irq_top_en_i | input | 1 | Top-level interrupt enable |
| level_mode_i | input | 1 | 0 = edge sensing, 1 = level sensing for flag bits 0 to 2 |
| clr_i | input | 9 | Write-one-to-clear mask, one bit per flag |
| flags_o | output | 9 | Pending flags: 0 tx idle, 1 tx free, 2 rx valid, 3/4 tx DMA A/B done, 5/6 rx DMA A/B done, 7 overrun, 8 underrun |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take for granted that every input is synchronous to `clk` and holds a single value for a whole cycle. They also assume that reset is not asserted again in the middle of a run, so a transition seen on the first cycle after release is measured against the values sampled during reset. The stimulus changes inputs only on the falling edge and applies the overrun, underrun and clear signals as one-cycle pulses. It switches `level_mode_i` only while the FIFO status lines are steady, so every edge the bench expects is an unambiguous change between two whole cycles.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NUM_FIFO_SRC = 3;
    localparam int NUM_DMA_BUF  = 2;
    localparam int NUM_EVT      = NUM_FIFO_SRC + 2 * NUM_DMA_BUF + 2;

    // Flag bit positions (LSB first): fifo sources, tx dma, rx dma, overrun, underrun
    localparam int BIT_TX_IDLE   = 0;
    localparam int BIT_TX_FREE   = 1;
    localparam int BIT_RX_VALID  = 2;
    localparam int BIT_TX_DMA0   = NUM_FIFO_SRC;
    localparam int BIT_RX_DMA0   = BIT_TX_DMA0 + NUM_DMA_BUF;
    localparam int BIT_OVERRUN   = BIT_RX_DMA0 + NUM_DMA_BUF;
    localparam int BIT_UNDERRUN  = BIT_OVERRUN + 1;

    typedef enum logic {
        SENSE_EDGE  = 1'b0,
        SENSE_LEVEL = 1'b1
    } sense_e;

    typedef struct packed {
        logic                   tx_underrun;
        logic                   rx_overrun;
        logic [NUM_DMA_BUF-1:0] rx_dma_done;
        logic [NUM_DMA_BUF-1:0] tx_dma_done;
        logic [NUM_FIFO_SRC-1:0] fifo;
    } evt_t;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    function automatic evt_vec_t merge_flags(evt_vec_t cur, evt_vec_t clr, evt_vec_t set);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/spi_irq_edge_sense.sv
module spi_irq_edge_sense #(
    parameter int W       = 1,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] pulse_o
);
    logic [W-1:0] prev_q;

    // Tracks the input during reset too, so levels present at release are not edges.
    always_ff @(posedge clk) begin
        prev_q <= sig_i;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse_o = prev_q & ~sig_i;
        end else begin : g_rise
            assign pulse_o = sig_i & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/spi_irq_fifo_src.sv
module spi_irq_fifo_src
    import spi_irq_pkg::*;
#(
    parameter int W = NUM_FIFO_SRC
) (
    input  logic         clk,
    input  logic [W-1:0] stat_i,
    input  sense_e       mode_i,
    output logic [W-1:0] set_o
);
    logic [W-1:0] rise;

    spi_irq_edge_sense #(.W(W), .FALLING(1'b0)) u_rise (
        .clk     (clk),
        .sig_i   (stat_i),
        .pulse_o (rise)
    );

    always_comb begin
        if (mode_i == SENSE_LEVEL) set_o = stat_i;
        else                       set_o = rise;
    end
endmodule

// File: rtl/spi_irq_flag_bank.sv
module spi_irq_flag_bank
    import spi_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t set_i,
    input  evt_vec_t clr_i,
    output evt_vec_t flags_o
);
    evt_vec_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= merge_flags(flags_q, clr_i, set_i);
    end

    assign flags_o = flags_q;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
        p_hold_r6: assert property (@(posedge clk) disable iff (rst)
            flags_q[i] && !clr_i[i] |=> flags_q[i]);
        p_clear_r6: assert property (@(posedge clk) disable iff (rst)
            flags_q[i] && clr_i[i] && !set_i[i] |=> !flags_q[i]);
        p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flags_q[i]);
    end
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags
    import spi_irq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tx_idle_i,
    input  logic                   tx_free_i,
    input  logic                   rx_valid_i,
    input  logic [NUM_DMA_BUF-1:0] tx_dma_act_i,
    input  logic [NUM_DMA_BUF-1:0] rx_dma_act_i,
    input  logic                   rx_overrun_i,
    input  logic                   tx_underrun_i,
    input  logic [NUM_EVT-1:0]     irq_en_i,
    input  logic                   irq_top_en_i,
    input  logic                   level_mode_i,
    input  logic [NUM_EVT-1:0]     clr_i,
    output logic [NUM_EVT-1:0]     flags_o,
    output logic                   irq_o
);
    evt_t                    ev;
    logic [NUM_FIFO_SRC-1:0] fifo_stat;
    logic [NUM_FIFO_SRC-1:0] fifo_set;
    logic [NUM_DMA_BUF-1:0]  tx_done;
    logic [NUM_DMA_BUF-1:0]  rx_done;
    sense_e                  mode;
    evt_vec_t                flags;

    assign fifo_stat = {rx_valid_i, tx_free_i, tx_idle_i};
    assign mode      = level_mode_i ? SENSE_LEVEL : SENSE_EDGE;

    spi_irq_fifo_src #(.W(NUM_FIFO_SRC)) u_fifo (
        .clk    (clk),
        .stat_i (fifo_stat),
        .mode_i (mode),
        .set_o  (fifo_set)
    );

    spi_irq_edge_sense #(.W(NUM_DMA_BUF), .FALLING(1'b1)) u_tx_dma (
        .clk     (clk),
        .sig_i   (tx_dma_act_i),
        .pulse_o (tx_done)
    );

    spi_irq_edge_sense #(.W(NUM_DMA_BUF), .FALLING(1'b1)) u_rx_dma (
        .clk     (clk),
        .sig_i   (rx_dma_act_i),
        .pulse_o (rx_done)
    );

    always_comb begin
        ev.fifo        = fifo_set;
        ev.tx_dma_done = tx_done;
        ev.rx_dma_done = rx_done;
        ev.rx_overrun  = rx_overrun_i;
        ev.tx_underrun = tx_underrun_i;
    end

    spi_irq_flag_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_i   (ev),
        .clr_i   (clr_i),
        .flags_o (flags)
    );

    assign flags_o = flags;
    assign irq_o   = irq_top_en_i & (|(flags & irq_en_i));

    p_edge_rise_r2: assert property (@(posedge clk) disable iff (rst)
        !level_mode_i && $rose(rx_valid_i) |=> flags_o[BIT_RX_VALID]);
    p_level_high_r3: assert property (@(posedge clk) disable iff (rst)
        level_mode_i && tx_idle_i |=> flags_o[BIT_TX_IDLE]);
    p_overrun_r5: assert property (@(posedge clk) disable iff (rst)
        rx_overrun_i |=> flags_o[BIT_OVERRUN]);
    p_underrun_r5: assert property (@(posedge clk) disable iff (rst)
        tx_underrun_i |=> flags_o[BIT_UNDERRUN]);
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !irq_top_en_i |-> !irq_o);
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flags_o != '0);

    for (genvar b = 0; b < NUM_DMA_BUF; b++) begin : g_dma_chk
        p_tx_dma_fall_r4: assert property (@(posedge clk) disable iff (rst)
            $fell(tx_dma_act_i[b]) |=> flags_o[BIT_TX_DMA0 + b]);
        p_rx_dma_fall_r4: assert property (@(posedge clk) disable iff (rst)
            $fell(rx_dma_act_i[b]) |=> flags_o[BIT_RX_DMA0 + b]);
    end
endmodule

// File: tb/tb_spi_irq_flags.sv
`timescale 1ns/1ps
module tb_spi_irq_flags;
    logic       clk = 1'b0;
    logic       rst;
    logic       tx_idle, tx_free, rx_valid;
    logic [1:0] tx_act, rx_act;
    logic       ovr, und;
    logic [8:0] en;
    logic       top_en, lvl;
    logic [8:0] clr;
    logic [8:0] flags;
    logic       irq;

    always #10 clk = ~clk;

    spi_irq_flags dut (
        .clk(clk), .rst(rst), .tx_idle_i(tx_idle), .tx_free_i(tx_free),
        .rx_valid_i(rx_valid), .tx_dma_act_i(tx_act), .rx_dma_act_i(rx_act),
        .rx_overrun_i(ovr), .tx_underrun_i(und), .irq_en_i(en),
        .irq_top_en_i(top_en), .level_mode_i(lvl), .clr_i(clr),
        .flags_o(flags), .irq_o(irq)
    );

    // staged stimulus
    logic       s_rst = 1'b1, s_idle = 1'b0, s_free = 1'b0, s_rxv = 1'b0;
    logic [1:0] s_tx = 2'b00, s_rx = 2'b00;
    logic       s_ovr = 1'b0, s_und = 1'b0, s_top = 1'b0, s_lvl = 1'b0;
    logic [8:0] s_en = '0, s_clr = '0;

    // reference model state
    logic [8:0] m_flags = '0;
    logic [2:0] m_prev_fifo = '0;
    logic [1:0] m_prev_tx = '0, m_prev_rx = '0;

    logic [8:0] q_flags[$];
    logic       q_irq[$];
    string      q_req[$];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic tick(input string req);
        logic [2:0] fifo, fset;
        logic [1:0] txd, rxd;
        @(negedge clk);
        rst = s_rst; tx_idle = s_idle; tx_free = s_free; rx_valid = s_rxv;
        tx_act = s_tx; rx_act = s_rx; ovr = s_ovr; und = s_und;
        en = s_en; top_en = s_top; lvl = s_lvl; clr = s_clr;
        fifo = {s_rxv, s_free, s_idle};
        if (s_rst) begin
            m_flags = '0;
        end else begin
            fset = s_lvl ? fifo : (fifo & ~m_prev_fifo);
            txd  = m_prev_tx & ~s_tx;
            rxd  = m_prev_rx & ~s_rx;
            m_flags = (m_flags & ~s_clr) | {s_und, s_ovr, rxd, txd, fset};
        end
        m_prev_fifo = fifo; m_prev_tx = s_tx; m_prev_rx = s_rx;
        q_flags.push_back(m_flags);
        q_irq.push_back(s_top & (|(m_flags & s_en)));
        q_req.push_back(req);
        s_ovr = 1'b0; s_und = 1'b0; s_clr = '0;
    endtask

    // monitor: samples mid high phase, after the edge that consumed the stimulus
    always @(posedge clk) begin
        #5;
        if (q_flags.size() > 0) begin
            logic [8:0] ef;
            logic       ei;
            string      r;
            ef = q_flags.pop_front();
            ei = q_irq.pop_front();
            r  = q_req.pop_front();
            checks++;
            if (flags !== ef) begin
                errors++;
                $display("FAIL %s flags actual=%b expected=%b", r, flags, ef);
            end
            checks++;
            if (irq !== ei) begin
                errors++;
                $display("FAIL %s irq actual=%b expected=%b", r, irq, ei);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tx_idle = 0; tx_free = 0; rx_valid = 0; tx_act = 0; rx_act = 0;
        ovr = 0; und = 0; en = 0; top_en = 0; lvl = 0; clr = 0;
        // R1: levels already high during reset must not become events
        s_idle = 1; s_tx = 2'b11; s_en = '1; s_top = 1;
        repeat (3) tick("R1");
        s_rst = 0;
        tick("R1");
        tick("R1");
        // R2: edge sensing on the fifo status lines
        s_idle = 0; tick("R2");
        s_idle = 1; tick("R2");           // bit0 set
        tick("R2");                        // holds
        s_clr = 9'b000000001; tick("R2"); // cleared while line high
        tick("R2");                        // stays clear
        s_free = 1; s_rxv = 1; tick("R2");
        // R4: dma completion on falling edge only
        s_tx = 2'b10; tick("R4");
        s_rx = 2'b01; tick("R4");          // rising: nothing
        s_rx = 2'b00; tick("R4");
        s_tx = 2'b00; tick("R4");
        s_rx = 2'b10; tick("R4");
        s_rx = 2'b00; tick("R4");
        // R6: clear everything, then a zero mask leaves flags alone
        s_clr = '1; tick("R6");
        s_ovr = 1; tick("R5");
        s_und = 1; tick("R5");
        s_clr = 9'b001111111; tick("R6"); // bits 7,8 unaffected
        tick("R6");
        // R7: event and clear in the same cycle
        s_ovr = 1; s_clr = 9'b010000000; tick("R7");
        s_clr = 9'b010000000; tick("R7");
        // R3: level sensing
        s_lvl = 1; tick("R3");             // bits 0..2 set from high levels
        s_clr = 9'b000000100; tick("R3");  // clear loses while rx_valid high
        s_rxv = 0; s_clr = 9'b000000100; tick("R3");
        tick("R3");
        s_idle = 0; s_free = 0; s_clr = 9'b000000011; tick("R3");
        s_lvl = 0; tick("R3");
        // R8 / R9: enables
        s_clr = '1; tick("R8");
        s_en = '0; s_und = 1; tick("R9"); // pending but masked
        tick("R9");
        s_en = 9'b100000000; tick("R9");   // unmasking raises irq
        s_top = 0; tick("R8");
        s_top = 1; s_en = 9'b011111111; tick("R8");
        s_rx = 2'b01; tick("R8");
        s_rx = 2'b00; tick("R8");          // bit5 done -> irq
        s_clr = 9'b000100000; tick("R6");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule